// File: doc/BRIEF.md
# SPI Master Serial-Clock Generator

This block produces the serial clock for an SPI controller running as bus master. It divides the system clock by a ratio set from three configuration inputs: a divide-by-sixteen extension, a one-bit factor select and a 4-bit prescale. One serial-clock period lasts 4·(2−factor)·(prescale+1) system clocks. With the extension bit set, the period is sixteen times longer. The block reads these inputs once, on the cycle after `enable` rises, and holds them until `enable` drops. Changes to the configuration inputs while enabled have no effect.

Words come from a transmit queue over a valid/ready handshake. `tx_valid` means the queue holds a word. The block raises `tx_ready` only when it can start a word at once. A word is taken on the clock edge where both signals are high. The queue may hold `tx_valid` high for any length of time, and the block never takes a word while `tx_ready` is low. After taking a word, the block runs eight serial-clock cycles. It pulses a sample strobe on each leading edge and a shift strobe on each trailing edge, stands in for the shift datapath. It pulses `done` on the last edge. When no word is waiting, the serial clock stays at its idle level.

The select input `sel_n` watches for another master. If it is low while the block is enabled, any transfer in progress stops, the clock returns to idle, and a sticky mode-fault flag is set. That flag blocks new words until `enable` is taken low.

Top module: `spi_sck_master`

## Requirements
- R1: While reset is active and just after it, `sck`, `tx_ready`, `busy`, `done`, `sample_stb`, `shift_stb` and `mode_fault` are all 0.
- R2: With `cfg_div16` = 0, the half-period is H = 2·(2−`cfg_fact`)·(`cfg_pm`+1) system clocks. The first `sck` edge comes H cycles after the accepting edge, and each later edge comes H cycles after the one before.
- R3: With `cfg_div16` = 1, the half-period H from R2 is multiplied by 16. Edge timing is otherwise the same as in R2.
- R4: Each word has exactly 16 `sck` edges. `sample_stb` is high for one cycle together with each odd-numbered edge (1st, 3rd, …), and `shift_stb` with each even-numbered edge. Neither strobe is high at any other time. `done` pulses for one cycle together with the 16th edge, which is H·16 cycles after acceptance.
- R5: When no word is in progress, `sck` sits at the idle level given by `cfg_cpol` as latched at enable. With `tx_valid` low, `sck` does not move and no strobe fires.
- R6: `tx_ready` is high only when the block is enabled, not busy, free of mode fault, and `sel_n` is high. A word starts on the edge where `tx_valid` and `tx_ready` are both high. `busy` is high and `tx_ready` is low until the word completes.
- R7: The configuration inputs are captured on the first clock edge with `enable` high. Changing them afterwards while enabled has no effect on timing or idle level.
- R8: `sel_n` low while enabled ends any transfer on the next edge. At that edge `busy` falls, `sck` returns to idle, `mode_fault` is set, and no `done` follows.
- R9: `mode_fault` stays set while `enable` remains high, even after `sel_n` returns high, and while set it keeps `tx_ready` low. It clears one cycle after `enable` is seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Master enable; configuration latched as it rises |
| cfg_div16 | input | 1 | Extra divide-by-16 select |
| cfg_fact | input | 1 | Factor select: 0 gives ×2, 1 gives ×1 |
| cfg_pm | input | 4 | Prescale; divide ratio scales by value+1 |
| cfg_cpol | input | 1 | Serial-clock idle level |
| sel_n | input | 1 | Active-low select; low while enabled is a mode fault |
| tx_valid | input | 1 | Transmit queue holds a word |
| tx_ready | output | 1 | Block will accept a word this cycle |
| sck | output | 1 | Serial clock |
| sample_stb | output | 1 | One-cycle pulse on each leading edge |
| shift_stb | output | 1 | One-cycle pulse on each trailing edge |
| done | output | 1 | One-cycle pulse on the final edge of a word |
| busy | output | 1 | A word is in progress |
| mode_fault | output | 1 | Sticky abort flag |

## Verification
A wrong half-period count would show up as a misplaced `sck` edge, either the first edge after acceptance or any later one. The bench compares each edge against a multiple of H and so catches the error within one half-period. A phase or bit counter that slips would cause one of three visible errors: strobes on the wrong edges, a `done` that fires before or after the 16th edge, or `sck` left off its idle level after the word. Each of these is seen within that word. A faulty abort path would show at the very next edge: `busy` still high, `sck` not idle, or a missing `mode_fault`. A faulty sticky path would let `tx_ready` rise again before `enable` drops.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // Left shift applied to the half-period when the extension divide is on.
  localparam int DIV_EXT_SHIFT = 4;

  // Extra counter bits beyond the prescale width: x2 half-period, x2 factor,
  // +1 for the prescale increment.
  localparam int BASE_EXTRA_BITS = 3;

endpackage

// File: rtl/spi_sck_cfg.sv
module spi_sck_cfg
  import spi_sck_pkg::*;
#(
  parameter int PM_W  = 4,
  parameter int CNT_W = PM_W + BASE_EXTRA_BITS + DIV_EXT_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cfg_div16,
  input  logic             cfg_fact,
  input  logic [PM_W-1:0]  cfg_pm,
  input  logic             cfg_cpol,
  output logic             en_q,
  output logic             cpol_q,
  output logic [CNT_W-1:0] half_m1
);

  logic [CNT_W-1:0] base_len;
  logic [CNT_W-1:0] full_len;
  logic             capture;

  // Half-period = 2*(2-fact)*(pm+1), optionally times 16.
  always_comb begin
    base_len = CNT_W'(cfg_pm) + CNT_W'(1);
    base_len = cfg_fact ? (base_len << 1) : (base_len << 2);
    full_len = cfg_div16 ? (base_len << DIV_EXT_SHIFT) : base_len;
  end

  assign capture = enable && !en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      cpol_q  <= 1'b0;
      half_m1 <= CNT_W'(1);
    end else begin
      en_q <= enable;
      if (capture) begin
        cpol_q  <= cfg_cpol;
        half_m1 <= full_len - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/spi_sck_timer.sv
module spi_sck_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] half_m1,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == half_m1);
  assign tick   = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || at_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/spi_sck_seq.sv
module spi_sck_seq
  import spi_sck_pkg::*;
#(
  parameter int WORD_BITS = 8,
  parameter int BIT_W     = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_q,
  input  logic cpol_q,
  input  logic sel_n,
  input  logic tx_valid,
  input  logic tick,
  output logic run,
  output logic tx_ready,
  output logic sck,
  output logic sample_stb,
  output logic shift_stb,
  output logic done,
  output logic mode_fault
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_BITS - 1);

  seq_state_e       state_q;
  logic             phase_q;
  logic [BIT_W-1:0] bit_q;
  logic             sck_q;
  logic             smp_q;
  logic             shf_q;
  logic             done_q;
  logic             fault_q;

  assign run        = (state_q == SEQ_RUN);
  assign tx_ready   = en_q && (state_q == SEQ_IDLE) && !fault_q && sel_n;
  assign sck        = sck_q;
  assign sample_stb = smp_q;
  assign shift_stb  = shf_q;
  assign done       = done_q;
  assign mode_fault = fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      phase_q <= 1'b0;
      bit_q   <= '0;
      sck_q   <= 1'b0;
      smp_q   <= 1'b0;
      shf_q   <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      smp_q  <= 1'b0;
      shf_q  <= 1'b0;
      done_q <= 1'b0;
      if (!en_q) begin
        state_q <= SEQ_IDLE;
        phase_q <= 1'b0;
        bit_q   <= '0;
        sck_q   <= cpol_q;
        fault_q <= 1'b0;
      end else if (!sel_n) begin
        state_q <= SEQ_IDLE;
        phase_q <= 1'b0;
        bit_q   <= '0;
        sck_q   <= cpol_q;
        fault_q <= 1'b1;
      end else if (state_q == SEQ_IDLE) begin
        phase_q <= 1'b0;
        bit_q   <= '0;
        sck_q   <= cpol_q;
        if (tx_valid && tx_ready) begin
          state_q <= SEQ_RUN;
        end
      end else if (tick) begin
        sck_q <= ~sck_q;
        if (!phase_q) begin
          phase_q <= 1'b1;
          smp_q   <= 1'b1;
        end else begin
          phase_q <= 1'b0;
          shf_q   <= 1'b1;
          if (bit_q == LAST_BIT) begin
            state_q <= SEQ_IDLE;
            bit_q   <= '0;
            done_q  <= 1'b1;
          end else begin
            bit_q <= bit_q + BIT_W'(1);
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_sck_master.sv
module spi_sck_master
  import spi_sck_pkg::*;
#(
  parameter int WORD_BITS = 8,
  parameter int PM_W      = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            cfg_div16,
  input  logic            cfg_fact,
  input  logic [PM_W-1:0] cfg_pm,
  input  logic            cfg_cpol,
  input  logic            sel_n,
  input  logic            tx_valid,
  output logic            tx_ready,
  output logic            sck,
  output logic            sample_stb,
  output logic            shift_stb,
  output logic            done,
  output logic            busy,
  output logic            mode_fault
);

  localparam int CNT_W = PM_W + BASE_EXTRA_BITS + DIV_EXT_SHIFT;

  logic             en_q;
  logic             cpol_q;
  logic [CNT_W-1:0] half_m1;
  logic             tick;
  logic             run;

  spi_sck_cfg #(
    .PM_W  (PM_W),
    .CNT_W (CNT_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .cfg_div16 (cfg_div16),
    .cfg_fact  (cfg_fact),
    .cfg_pm    (cfg_pm),
    .cfg_cpol  (cfg_cpol),
    .en_q      (en_q),
    .cpol_q    (cpol_q),
    .half_m1   (half_m1)
  );

  spi_sck_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .half_m1 (half_m1),
    .tick    (tick)
  );

  spi_sck_seq #(
    .WORD_BITS (WORD_BITS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_q       (en_q),
    .cpol_q     (cpol_q),
    .sel_n      (sel_n),
    .tx_valid   (tx_valid),
    .tick       (tick),
    .run        (run),
    .tx_ready   (tx_ready),
    .sck        (sck),
    .sample_stb (sample_stb),
    .shift_stb  (shift_stb),
    .done       (done),
    .mode_fault (mode_fault)
  );

  assign busy = run;

endmodule

// File: rtl/spi_sck_master_chk.sv
module spi_sck_master_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic sel_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic sck,
  input logic sample_stb,
  input logic shift_stb,
  input logic done,
  input logic busy,
  input logic mode_fault
);

  AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !busy) else $error("ready while busy"); // R6

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> busy) else $error("accept did not start"); // R6

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && shift_stb)) else $error("both strobes"); // R4

  AST_STROBE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb || shift_stb) |-> (sck != $past(sck))) else $error("strobe off edge"); // R4

  AST_DONE_ENDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (shift_stb && !busy)) else $error("done misplaced"); // R4

  AST_SEL_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sel_n && enable && $past(enable)) |=> (!busy && mode_fault && !done))
    else $error("abort failed"); // R8

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_fault && enable && $past(enable)) |=> mode_fault) else $error("fault lost"); // R9

  AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault |-> !tx_ready) else $error("ready during fault"); // R9

endmodule

bind spi_sck_master spi_sck_master_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .sel_n      (sel_n),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .sck        (sck),
  .sample_stb (sample_stb),
  .shift_stb  (shift_stb),
  .done       (done),
  .busy       (busy),
  .mode_fault (mode_fault)
);

// File: tb/spi_sck_master_tb.sv
`timescale 1ns/1ps
module spi_sck_master_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       cfg_div16 = 1'b0;
  logic       cfg_fact = 1'b0;
  logic [3:0] cfg_pm = 4'd0;
  logic       cfg_cpol = 1'b0;
  logic       sel_n = 1'b1;
  logic       tx_valid = 1'b0;
  logic       tx_ready, sck, sample_stb, shift_stb, done, busy, mode_fault;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  spi_sck_master u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_div16(cfg_div16),
    .cfg_fact(cfg_fact), .cfg_pm(cfg_pm), .cfg_cpol(cfg_cpol), .sel_n(sel_n),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .sck(sck), .sample_stb(sample_stb),
    .shift_stb(shift_stb), .done(done), .busy(busy), .mode_fault(mode_fault)
  );

  // Vector: {div16, fact, pm[3:0], cpol}
  localparam int NVEC = 7;
  localparam logic [6:0] VEC [NVEC] = '{
    7'b0_1_0000_0, 7'b0_0_0000_1, 7'b0_1_0011_0, 7'b0_0_0010_1,
    7'b1_1_0000_0, 7'b1_0_0001_1, 7'b0_0_1111_0
  };

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int half_of(input logic d, input logic f, input logic [3:0] p);
    int h;
    h = 2 * (f ? 1 : 2) * (int'(p) + 1);
    return d ? h * 16 : h;
  endfunction

  task automatic configure(input logic d, input logic f, input logic [3:0] p, input logic pol);
    @(negedge clk); enable = 1'b0;
    repeat (2) @(negedge clk);
    cfg_div16 = d; cfg_fact = f; cfg_pm = p; cfg_cpol = pol; enable = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_word(input int h, input logic pol, input string rq);
    int cyc = 0;
    int edges = 0;
    int bad_iv = 0;
    int bad_stb = 0;
    int done_cyc = -1;
    logic prev;
    @(negedge clk);
    check(tx_ready === 1'b1, "R6 ready before word", int'(tx_ready), 1);
    prev = sck;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    check(busy === 1'b1 && tx_ready === 1'b0, "R6 busy after accept", int'(busy), 1);
    while (done_cyc < 0 && cyc < 20 * h + 10) begin
      @(negedge clk);
      cyc++;
      if (sck !== prev) begin
        edges++;
        prev = sck;
        if (cyc != edges * h) bad_iv++;
        if ((edges % 2) == 1) begin
          if (!(sample_stb && !shift_stb)) bad_stb++;
        end else begin
          if (!(shift_stb && !sample_stb)) bad_stb++;
        end
      end else if (sample_stb || shift_stb) begin
        bad_stb++;
      end
      if (done) done_cyc = cyc;
    end
    check(bad_iv == 0, rq, bad_iv, 0);
    check(bad_stb == 0, "R4 strobes", bad_stb, 0);
    check(edges == 16, "R4 edge count", edges, 16);
    check(done_cyc == 16 * h, "R4 done timing", done_cyc, 16 * h);
    @(negedge clk);
    check(sck === pol && busy === 1'b0, "R5 idle after word", int'(sck), int'(pol));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int moves;
    int stbs;
    logic prev;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(sck === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 in reset", int'(sck), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_ready === 1'b0 && mode_fault === 1'b0 && sample_stb === 1'b0 && shift_stb === 1'b0,
          "R1 after reset", int'(tx_ready), 0);
    // R6 disabled block refuses words
    tx_valid = 1'b1;
    repeat (5) @(negedge clk);
    check(busy === 1'b0 && tx_ready === 1'b0, "R6 disabled", int'(busy), 0);
    tx_valid = 1'b0;

    // Table walk: R2 / R3 timing
    for (int i = 0; i < NVEC; i++) begin
      logic d, f, pol;
      logic [3:0] p;
      d = VEC[i][6]; f = VEC[i][5]; p = VEC[i][4:1]; pol = VEC[i][0];
      configure(d, f, p, pol);
      check(sck === pol, "R5 idle level", int'(sck), int'(pol));
      run_word(half_of(d, f, p), pol, d ? "R3 div16 timing" : "R2 edge timing");
    end

    // R5 empty queue holds sck
    configure(1'b0, 1'b1, 4'd0, 1'b1);
    moves = 0; stbs = 0; prev = sck;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (sck !== prev) moves++;
      if (sample_stb || shift_stb || busy) stbs++;
    end
    check(moves == 0 && stbs == 0, "R5 empty queue", moves + stbs, 0);

    // R7 config changes while enabled are ignored
    configure(1'b0, 1'b1, 4'd0, 1'b0);
    cfg_pm = 4'd7; cfg_fact = 1'b0; cfg_cpol = 1'b1; cfg_div16 = 1'b1;
    repeat (2) @(negedge clk);
    check(sck === 1'b0, "R7 idle level kept", int'(sck), 0);
    run_word(2, 1'b0, "R7 timing kept");

    // R8 abort mid-word
    configure(1'b0, 1'b1, 4'd3, 1'b1);
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (20) @(negedge clk);
    sel_n = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && sck === 1'b1 && mode_fault === 1'b1, "R8 abort", int'(busy), 0);
    stbs = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (done || sample_stb || shift_stb) stbs++;
    end
    check(stbs == 0, "R8 no done after abort", stbs, 0);

    // R9 sticky fault blocks words
    sel_n = 1'b1;
    tx_valid = 1'b1;
    repeat (20) @(negedge clk);
    check(mode_fault === 1'b1 && tx_ready === 1'b0 && busy === 1'b0, "R9 sticky",
          int'(mode_fault), 1);
    tx_valid = 1'b0;
    enable = 1'b0;
    repeat (2) @(negedge clk);
    check(mode_fault === 1'b0, "R9 clear on disable", int'(mode_fault), 0);

    // R8 select low while idle also faults
    configure(1'b0, 1'b1, 4'd0, 1'b0);
    sel_n = 1'b0;
    @(negedge clk);
    sel_n = 1'b1;
    @(negedge clk);
    check(mode_fault === 1'b1 && tx_ready === 1'b0, "R8 idle fault", int'(mode_fault), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule